// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A general-purpose 16-bit timer with a small register port. A control word selects a clock source and an 8-bit prescale value. The counter advances once per prescaled tick and is compared against a programmable reference value. When the count reaches the reference, the timer latches a reference event flag. On the following tick the count returns to zero.

The event flags live in a register that software clears by writing ones. The interrupt line is a level. It stays high while the reference event flag is set and its enable bit in the control word is on.

The counter can be loaded directly at any time. A capture register is kept as plain storage for software. Writing the control word with the enable bit going from one to zero clears both the control word and the reference value.

Top module: `refcmp_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low.
- R2: Byte offsets are: 0x00 control, 0x04 reference, 0x08 capture, 0x0C counter, 0x11 events. Event bit 1 is the reference flag and bit 0 is the capture flag. A write to 0x0C loads the counter. Any other offset reads as 0, and a write to it changes nothing.
- R3: With source field (control bits 2:1) equal to 1, one tick occurs every (control bits 15:8 + 1) clock cycles. This is counted from the control or reference write that started the prescaler.
- R4: With source field equal to 2, the tick period is 16 times (control bits 15:8 + 1) cycles.
- R5: The counter holds its value unless all of the following are true: enable (control bit 0) is 1, restart (control bit 3) is 1, and the source field is 1 or 2. Source values 0 and 3 stop the counter.
- R6: On the tick that makes the count equal the reference, event bit 1 is set. On the next tick the count returns to 0.
- R7: A write to the event offset clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R8: `irq` is high exactly when control bit 4 and event bit 1 are both 1.
- R9: A control write with bit 0 low, while control bit 0 is currently high, leaves both the control and reference registers at 0.
- R10: Every write to the control or reference register restarts the prescaler phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates on the same edge |
| addr | input | 5 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The properties assume that `addr` and `wdata` are valid whenever `wr_en` is high. They also assume that at most one register is touched per cycle, so the hold and wrap checks exclude only a counter load in the same cycle. The bench changes every input on the falling clock edge and issues exactly one access per cycle through its tasks. Cycle counts are therefore fixed from the write edge that starts the prescaler, and the expected tick edges can be computed exactly.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
  // byte offsets of the register port
  localparam int OFF_CTL = 'h00;
  localparam int OFF_REF = 'h04;
  localparam int OFF_CAP = 'h08;
  localparam int OFF_CNT = 'h0C;
  localparam int OFF_EVT = 'h11;

  // control word bit positions
  localparam int CB_EN      = 0;
  localparam int CB_SRC_LO  = 1;
  localparam int CB_RESTART = 3;
  localparam int CB_IE      = 4;
  localparam int CB_PSC_LO  = 8;

  // event bit positions
  localparam int EB_CAP = 0;
  localparam int EB_REF = 1;
  localparam int EVT_W  = 2;

  typedef enum logic [1:0] {
    SRC_STOP0 = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_STOP3 = 2'd3
  } src_e;
endpackage

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler #(
  parameter int PSC_W   = 8,
  parameter int EXT_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic             slow,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick
);
  localparam int DIV_W = PSC_W + EXT_LOG;

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] div_m1;

  // (p+1)*2^EXT_LOG - 1 == {p, all ones}
  assign div_m1 = slow ? {psc_val, {EXT_LOG{1'b1}}}
                       : {{EXT_LOG{1'b0}}, psc_val};
  assign tick   = run && (phase == div_m1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase <= '0;
    else if (tick)              phase <= '0;
    else                        phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] nxt;

  assign nxt = (cnt == ref_val) ? '0 : cnt + CNT_W'(1);
  assign hit = tick && !load && (nxt == ref_val);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= nxt;
  end
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int EXT_LOG = 4,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PSC_W = DATA_W - CB_PSC_LO;

  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic [DATA_W-1:0] ref_q, ref_d;
  logic [DATA_W-1:0] cap_q;
  logic [EVT_W-1:0]  evt_q, evt_d;
  logic [DATA_W-1:0] cnt;
  logic              tick, hit;

  logic wr_ctl, wr_ref, wr_cap, wr_cnt, wr_evt, en_fall;
  logic run, slow;
  src_e src;

  assign wr_ctl = wr_en && (addr == ADDR_W'(OFF_CTL));
  assign wr_ref = wr_en && (addr == ADDR_W'(OFF_REF));
  assign wr_cap = wr_en && (addr == ADDR_W'(OFF_CAP));
  assign wr_cnt = wr_en && (addr == ADDR_W'(OFF_CNT));
  assign wr_evt = wr_en && (addr == ADDR_W'(OFF_EVT));

  assign en_fall = wr_ctl && ctl_q[CB_EN] && !wdata[CB_EN];

  assign src  = src_e'(ctl_q[CB_SRC_LO +: 2]);
  assign slow = (src == SRC_SLOW);
  assign run  = ctl_q[CB_EN] && ctl_q[CB_RESTART] &&
                ((src == SRC_SYS) || (src == SRC_SLOW));

  refcmp_prescaler #(.PSC_W(PSC_W), .EXT_LOG(EXT_LOG)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_ctl || wr_ref),
    .run     (run),
    .slow    (slow),
    .psc_val (ctl_q[CB_PSC_LO +: PSC_W]),
    .tick    (tick)
  );

  refcmp_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (wdata),
    .ref_val  (ref_q),
    .cnt      (cnt),
    .hit      (hit)
  );

  always_comb begin
    ctl_d = ctl_q;
    ref_d = ref_q;
    if (en_fall) begin
      ctl_d = '0;
      ref_d = '0;
    end else begin
      if (wr_ctl) ctl_d = wdata;
      if (wr_ref) ref_d = wdata;
    end
    evt_d = evt_q & ~(wr_evt ? wdata[EVT_W-1:0] : {EVT_W{1'b0}});
    if (hit) evt_d[EB_REF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ref_q <= '0;
      cap_q <= '0;
      evt_q <= '0;
      irq   <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      ref_q <= ref_d;
      evt_q <= evt_d;
      if (wr_cap) cap_q <= wdata;
      irq   <= ctl_d[CB_IE] && evt_d[EB_REF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if      (addr == ADDR_W'(OFF_CTL)) rdata <= ctl_q;
      else if (addr == ADDR_W'(OFF_REF)) rdata <= ref_q;
      else if (addr == ADDR_W'(OFF_CAP)) rdata <= cap_q;
      else if (addr == ADDR_W'(OFF_CNT)) rdata <= cnt;
      else if (addr == ADDR_W'(OFF_EVT)) rdata <= {{(DATA_W-EVT_W){1'b0}}, evt_q};
      else                               rdata <= '0;
    end
  end
endmodule

// File: rtl/refcmp_timer_sva.sv
module refcmp_timer_sva
  import refcmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ctl_q,
  input logic [DATA_W-1:0] ref_q,
  input logic [EVT_W-1:0]  evt_q,
  input logic [DATA_W-1:0] cnt,
  input logic              tick,
  input logic              irq
);
  logic cnt_load;
  assign cnt_load = wr_en && (addr == ADDR_W'(OFF_CNT));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (ctl_q[CB_IE] && evt_q[EB_REF]));

  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CB_EN] && !cnt_load) |=> $stable(cnt));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt == ref_q) && !cnt_load) |=> (cnt == '0));

  a_r9_enable_fall_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(OFF_CTL)) && ctl_q[CB_EN] && !wdata[CB_EN])
      |=> (ctl_q == '0 && ref_q == '0));

  a_r7_w1c_ref: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(OFF_EVT)) && wdata[EB_REF] && !tick)
      |=> !evt_q[EB_REF]);
endmodule

bind refcmp_timer refcmp_timer_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .ctl_q (ctl_q),
  .ref_q (ref_q),
  .evt_q (evt_q),
  .cnt   (cnt),
  .tick  (tick),
  .irq   (irq)
);

// File: tb/refcmp_timer_tb.sv
module refcmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  refcmp_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {write, addr, data, expected}
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'h04, 16'hBEEF, 16'h0000},  // R2 reference
    {1'b0, 5'h04, 16'h0000, 16'hBEEF},
    {1'b1, 5'h08, 16'h1234, 16'h0000},  // R2 capture storage
    {1'b0, 5'h08, 16'h0000, 16'h1234},
    {1'b1, 5'h00, 16'hA536, 16'h0000},  // R2 control, enable low
    {1'b0, 5'h00, 16'h0000, 16'hA536},
    {1'b1, 5'h0C, 16'h00AA, 16'h0000},  // R2 counter load
    {1'b0, 5'h0C, 16'h0000, 16'h00AA},  // R5 held while disabled
    {1'b1, 5'h10, 16'hFFFF, 16'h0000},  // R2 unmapped write
    {1'b0, 5'h10, 16'h0000, 16'h0000},
    {1'b0, 5'h14, 16'h0000, 16'h0000},
    {1'b0, 5'h1F, 16'h0000, 16'h0000},
    {1'b0, 5'h11, 16'h0000, 16'h0000},
    {1'b1, 5'h00, 16'h0000, 16'h0000},  // no enable fall: ref kept
    {1'b0, 5'h04, 16'h0000, 16'hBEEF},
    {1'b0, 5'h08, 16'h0000, 16'h1234},
    {1'b0, 5'h0C, 16'h0000, 16'h00AA}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each task starts at a falling edge and consumes exactly one rising edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic setup();
    wr(5'h00, 16'h0000);
    wr(5'h0C, 16'h0000);
    wr(5'h11, 16'h0003);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd_chk("R1 ctl", 5'h00, 16'h0);
    rd_chk("R1 ref", 5'h04, 16'h0);
    rd_chk("R1 cnt", 5'h0C, 16'h0);
    rd_chk("R1 evt", 5'h11, 16'h0);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:16]);
      else            rd_chk($sformatf("R2 table[%0d]", i), VEC[i][36:32], VEC[i][15:0]);
    end

    // R3 prescale 3: ticks at edges 3 and 6, ref=2 hit at 6
    setup();
    wr(5'h04, 16'h0002);
    wr(5'h00, 16'h021B);
    repeat (5) @(negedge clk);
    check("R3 before tick", {15'b0, irq}, 16'h0);
    @(negedge clk);
    check("R3 at tick", {15'b0, irq}, 16'h1);

    // R4 slow source: first tick 16 cycles after start
    setup();
    wr(5'h04, 16'h0001);
    wr(5'h00, 16'h001D);
    repeat (15) @(negedge clk);
    check("R4 before tick", {15'b0, irq}, 16'h0);
    @(negedge clk);
    check("R4 at tick", {15'b0, irq}, 16'h1);

    // R6 count sequence with wrap, irq disabled
    setup();
    wr(5'h04, 16'h0003);
    wr(5'h00, 16'h000B);
    rd_chk("R6 count0", 5'h0C, 16'h0000);
    rd_chk("R6 count1", 5'h0C, 16'h0001);
    rd_chk("R6 count2", 5'h0C, 16'h0002);
    rd_chk("R6 count3", 5'h0C, 16'h0003);
    rd_chk("R6 wrap",   5'h0C, 16'h0000);
    rd_chk("R6 flag",   5'h11, 16'h0002);
    check("R8 gated off", {15'b0, irq}, 16'h0);

    // R7 write-one-to-clear
    wr(5'h00, 16'h0003);
    rd_chk("R7 ctl kept", 5'h00, 16'h0003);
    wr(5'h11, 16'h0001);
    rd_chk("R7 other bit", 5'h11, 16'h0002);
    wr(5'h11, 16'h0002);
    rd_chk("R7 cleared", 5'h11, 16'h0000);

    // R8 interrupt gating
    setup();
    wr(5'h04, 16'h0002);
    wr(5'h00, 16'h001B);
    repeat (2) @(negedge clk);
    check("R8 raised", {15'b0, irq}, 16'h1);
    wr(5'h00, 16'h0013);
    check("R8 held", {15'b0, irq}, 16'h1);
    wr(5'h00, 16'h0003);
    check("R8 enable off", {15'b0, irq}, 16'h0);
    wr(5'h00, 16'h0013);
    check("R8 enable on", {15'b0, irq}, 16'h1);
    wr(5'h11, 16'h0002);
    check("R8 flag cleared", {15'b0, irq}, 16'h0);

    // R9 enable falling edge clears control and reference
    wr(5'h00, 16'h0010);
    rd_chk("R9 ctl", 5'h00, 16'h0000);
    rd_chk("R9 ref", 5'h04, 16'h0000);

    // R5 stopped sources and restart bit
    setup();
    wr(5'h04, 16'hFFFF);
    wr(5'h0C, 16'h0005);
    wr(5'h00, 16'h0019);
    repeat (10) @(negedge clk);
    rd_chk("R5 src0", 5'h0C, 16'h0005);
    wr(5'h00, 16'h001F);
    repeat (10) @(negedge clk);
    rd_chk("R5 src3", 5'h0C, 16'h0005);
    wr(5'h00, 16'h0013);
    repeat (10) @(negedge clk);
    rd_chk("R5 no restart", 5'h0C, 16'h0005);

    // R10 reference write restarts prescaler (divisor 4)
    setup();
    wr(5'h04, 16'h0001);
    wr(5'h00, 16'h031B);
    @(negedge clk);
    wr(5'h04, 16'h0001);
    repeat (3) @(negedge clk);
    check("R10 no early tick", {15'b0, irq}, 16'h0);
    @(negedge clk);
    check("R10 tick after restart", {15'b0, irq}, 16'h1);

    // R1 reset while running
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
    rd_chk("R1 ctl after reset", 5'h00, 16'h0);
    rd_chk("R1 evt after reset", 5'h11, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule